// File: doc/BRIEF.md
# Translation Buffer Pointer Register Bank

This block holds the per-side base and configuration registers that locate the in-memory translation storage buffer. It also forms, without any clock delay, the four buffer entry pointers that a miss handler needs: page size 0 and page size 1 for the data side, and the same pair for the instruction side. Each side has two register sets. One is used for the kernel context, where the context field of the tag-access value is zero. The other is used for every other context. Each side also keeps its own tag-access register.

Software writes and reads the registers through a simple port. The write address and the read address are separate, so a write and a read can occur in the same cycle. Reads are combinational. Writes take effect at the clock edge. The pointer outputs follow the register contents. One read-only address per side returns the tag-target view of that side's tag-access register.

Top module: `tsbp_regbank`

## Requirements
- R1: After reset every register holds zero, every read address returns zero, and all four pointer outputs are zero.
- R2: Address bit 3 selects the side (0 data, 1 instruction). Bits 2:0 select the register: 0 base page size 0 for context zero, 1 base page size 1 for context zero, 2 configuration for context zero, 3 base page size 0 for other contexts, 4 base page size 1 for other contexts, 5 configuration for other contexts, 6 tag-access. A write to any of these addresses is read back exactly, starting in the cycle after the write.
- R3: Reading bits 2:0 = 7 returns that side's tag-target value. Bits 41:0 hold tag-access bits 63:22. Bits 60:48 hold tag-access bits 12:0. All other bits are zero.
- R4: A write to an address with bits 2:0 = 7 has no effect. No register, no read value and no pointer output changes.
- R5: When tag-access bits 12:0 are all zero, a pointer uses the context-zero base and configuration registers. Otherwise it uses the other-context registers.
- R6: A pointer is built as follows. Take the selected base with bits 12:0 cleared. OR in the tag-access value shifted right by 9 + 3*code, masked to bits (12+size) down to 4. Here size is base bits 3:0 and code is the page-size code. Pointer bits 3:0 are always zero.
- R7: The page-size code is configuration bits 2:0 for the page-size-0 pointer and configuration bits 10:8 for the page-size-1 pointer.
- R8: When base bit 12 (split) is set, the page-size-1 pointer has bit (13+size) forced to one. The page-size-0 pointer ignores the split bit.
- R9: The data pointers depend only on the data-side registers, and the instruction pointers depend only on the instruction-side registers.
- R10: The pointer outputs change in the cycle after a register write and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (side bit and register index) |
| wr_data | input | 64 | Write data |
| rd_addr | input | 4 | Read address (side bit and register index) |
| rd_data | output | 64 | Combinational read data |
| dptr_ps0 | output | 64 | Data-side page size 0 pointer |
| dptr_ps1 | output | 64 | Data-side page size 1 pointer |
| iptr_ps0 | output | 64 | Instruction-side page size 0 pointer |
| iptr_ps1 | output | 64 | Instruction-side page size 1 pointer |

## Verification
A register write and a read of the same register, or a write to tag-access while the pointers are observed, can land in the same cycle. The bench provokes this by holding the write strobe on the tag-access address and the read address on that same register. It samples before the edge to confirm that the old value and old pointers are still visible. It samples after the edge to confirm that the new value and the recomputed pointers appear together. Writes to the read-only tag-target address are issued alongside a read of it, and the read value must stay unchanged.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;
   localparam int unsigned WORD_W = 64;
   localparam int unsigned SEL_W  = 3;
   localparam int unsigned NSIDE  = 2;
   localparam int unsigned NPS    = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_BASE0_K  = 3'd0,
      SEL_BASE1_K  = 3'd1,
      SEL_CFG_K    = 3'd2,
      SEL_BASE0_U  = 3'd3,
      SEL_BASE1_U  = 3'd4,
      SEL_CFG_U    = 3'd5,
      SEL_TAGACC   = 3'd6,
      SEL_TAGTGT   = 3'd7
   } reg_sel_e;

   localparam int unsigned NREG = 7;
   localparam int unsigned SIDE_DATA = 0;
   localparam int unsigned SIDE_INST = 1;
endpackage

// File: rtl/tsbp_side_regs.sv
module tsbp_side_regs #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned NREG   = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             wr_sel,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [NREG-1:0][DATA_W-1:0]  regs_o
);
   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   if (NREG >= SEL_SPAN) begin : g_bad_nreg
      $error("tsbp_side_regs: NREG must leave one read-only index");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_o[r] <= '0;
         end else if (hit) begin
            regs_o[r] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/tsbp_tt_fmt.sv
module tsbp_tt_fmt #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned CTX_W      = 13,
   parameter int unsigned TT_VA_LO   = 22,
   parameter int unsigned TT_CTX_POS = 48
) (
   input  logic [DATA_W-1:0] tag_access,
   output logic [DATA_W-1:0] tag_target
);
   localparam int unsigned VA_W = DATA_W - TT_VA_LO;

   if (TT_CTX_POS + CTX_W > DATA_W || VA_W > TT_CTX_POS) begin : g_bad_fmt
      $error("tsbp_tt_fmt: context field does not fit above the address field");
   end

   logic [DATA_W-1:0] va_part;
   logic [DATA_W-1:0] ctx_part;

   assign va_part  = DATA_W'(tag_access[DATA_W-1:TT_VA_LO]);
   assign ctx_part = DATA_W'(tag_access[CTX_W-1:0]) << TT_CTX_POS;
   assign tag_target = va_part | ctx_part;

   logic unused_ta_mid;
   assign unused_ta_mid = ^tag_access[TT_VA_LO-1:CTX_W];
endmodule

// File: rtl/tsbp_ptr_calc.sv
module tsbp_ptr_calc #(
   parameter int unsigned DATA_W     = 64,
   parameter bit          PAGE_SIZE1 = 1'b0,
   parameter int unsigned CTX_W      = 13,
   parameter int unsigned BASE_LO    = 13,
   parameter int unsigned SPLIT_BIT  = 12,
   parameter int unsigned SIZE_W     = 4,
   parameter int unsigned PGC_W      = 3,
   parameter int unsigned PGC1_LO    = 8,
   parameter int unsigned IDX_LO     = 4,
   parameter int unsigned IDX_BASE   = 12,
   parameter int unsigned SHIFT_BASE = 9,
   parameter int unsigned SHIFT_MUL  = 3
) (
   input  logic [DATA_W-1:0] tag_access,
   input  logic [DATA_W-1:0] base_k,
   input  logic [DATA_W-1:0] base_u,
   input  logic [DATA_W-1:0] cfg_k,
   input  logic [DATA_W-1:0] cfg_u,
   output logic [DATA_W-1:0] ptr
);
   localparam int unsigned AMT_W = $clog2(DATA_W) + 1;
   localparam int unsigned MAX_HI = IDX_BASE + (1 << SIZE_W) - 1;

   if (MAX_HI + 2 > DATA_W) begin : g_bad_size
      $error("tsbp_ptr_calc: index field can exceed the word");
   end
   if (SPLIT_BIT >= BASE_LO || SIZE_W > SPLIT_BIT) begin : g_bad_fields
      $error("tsbp_ptr_calc: base register fields overlap");
   end
   if (PGC1_LO + PGC_W > DATA_W) begin : g_bad_pgc
      $error("tsbp_ptr_calc: page code field exceeds the word");
   end

   logic              ctx_zero;
   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] cfg;
   logic [SIZE_W-1:0] size_code;
   logic              split;
   logic [PGC_W-1:0]  pg_code;
   logic [AMT_W-1:0]  shamt;
   logic [AMT_W-1:0]  idx_hi;
   logic [DATA_W-1:0] idx_mask;
   logic [DATA_W-1:0] idx_bits;
   logic [DATA_W-1:0] split_bit;
   logic [DATA_W-1:0] base_bits;

   assign ctx_zero  = (tag_access[CTX_W-1:0] == '0);
   assign base      = ctx_zero ? base_k : base_u;
   assign cfg       = ctx_zero ? cfg_k  : cfg_u;
   assign size_code = base[SIZE_W-1:0];
   assign split     = base[SPLIT_BIT];

   if (PAGE_SIZE1) begin : g_ps1
      assign pg_code = cfg[PGC1_LO +: PGC_W];
      assign split_bit = split ? (DATA_W'(1) << (AMT_W'(BASE_LO) + AMT_W'(size_code)))
                               : '0;
      logic unused_cfg;
      assign unused_cfg = ^{cfg[DATA_W-1:PGC1_LO+PGC_W], cfg[PGC1_LO-1:0]};
   end else begin : g_ps0
      assign pg_code   = cfg[PGC_W-1:0];
      assign split_bit = '0;
      logic unused_cfg;
      assign unused_cfg = ^{cfg[DATA_W-1:PGC_W], split};
   end

   assign shamt     = AMT_W'(SHIFT_BASE) + AMT_W'(SHIFT_MUL) * AMT_W'(pg_code);
   assign idx_hi    = AMT_W'(IDX_BASE) + AMT_W'(size_code);
   assign idx_mask  = ({DATA_W{1'b1}} >> (AMT_W'(DATA_W - 1) - idx_hi))
                      & ~((DATA_W'(1) << IDX_LO) - DATA_W'(1));
   assign idx_bits  = (tag_access >> shamt) & idx_mask;
   assign base_bits = {base[DATA_W-1:BASE_LO], {BASE_LO{1'b0}}};
   assign ptr       = base_bits | split_bit | idx_bits;

   logic unused_base;
   assign unused_base = ^base[BASE_LO-1:SIZE_W];
endmodule

// File: rtl/tsbp_regbank.sv
module tsbp_regbank #(
   parameter int unsigned DATA_W     = tsbp_pkg::WORD_W,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned CTX_W      = 13,
   parameter int unsigned TT_VA_LO   = 22,
   parameter int unsigned TT_CTX_POS = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dptr_ps0,
   output logic [DATA_W-1:0] dptr_ps1,
   output logic [DATA_W-1:0] iptr_ps0,
   output logic [DATA_W-1:0] iptr_ps1
);
   import tsbp_pkg::*;

   localparam int unsigned SIDE_BIT = ADDR_W - 1;

   if (ADDR_W != SEL_W + 1) begin : g_bad_addr
      $error("tsbp_regbank: address must be one side bit plus the register index");
   end
   if (DATA_W != WORD_W) begin : g_bad_width
      $error("tsbp_regbank: field positions assume a 64-bit word");
   end

   logic [NSIDE-1:0][NREG-1:0][DATA_W-1:0] regs;
   logic [NSIDE-1:0][DATA_W-1:0]           tgt;
   logic [NSIDE-1:0][NPS-1:0][DATA_W-1:0]  ptrs;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      logic side_wr;
      assign side_wr = wr_en && (wr_addr[SIDE_BIT] == 1'(s));

      tsbp_side_regs #(
         .DATA_W (DATA_W),
         .SEL_W  (SEL_W),
         .NREG   (NREG)
      ) regs_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (side_wr),
         .wr_sel  (wr_addr[SEL_W-1:0]),
         .wr_data (wr_data),
         .regs_o  (regs[s])
      );

      tsbp_tt_fmt #(
         .DATA_W     (DATA_W),
         .CTX_W      (CTX_W),
         .TT_VA_LO   (TT_VA_LO),
         .TT_CTX_POS (TT_CTX_POS)
      ) tt_i (
         .tag_access (regs[s][SEL_TAGACC]),
         .tag_target (tgt[s])
      );

      for (genvar p = 0; p < NPS; p++) begin : g_ps
         tsbp_ptr_calc #(
            .DATA_W     (DATA_W),
            .PAGE_SIZE1 (p == 1),
            .CTX_W      (CTX_W)
         ) ptr_i (
            .tag_access (regs[s][SEL_TAGACC]),
            .base_k     (regs[s][(p == 0) ? SEL_BASE0_K : SEL_BASE1_K]),
            .base_u     (regs[s][(p == 0) ? SEL_BASE0_U : SEL_BASE1_U]),
            .cfg_k      (regs[s][SEL_CFG_K]),
            .cfg_u      (regs[s][SEL_CFG_U]),
            .ptr        (ptrs[s][p])
         );
      end
   end

   logic                 rd_side;
   logic [SEL_W-1:0]     rd_sel;

   assign rd_side = rd_addr[SIDE_BIT];
   assign rd_sel  = rd_addr[SEL_W-1:0];

   always_comb begin
      if (rd_sel == SEL_TAGTGT) begin
         rd_data = tgt[rd_side];
      end else begin
         rd_data = regs[rd_side][rd_sel];
      end
   end

   assign dptr_ps0 = ptrs[SIDE_DATA][0];
   assign dptr_ps1 = ptrs[SIDE_DATA][1];
   assign iptr_ps0 = ptrs[SIDE_INST][0];
   assign iptr_ps1 = ptrs[SIDE_INST][1];
endmodule

// File: rtl/tsbp_regbank_chk.sv
module tsbp_regbank_chk #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned CTX_W      = 13,
   parameter int unsigned TT_VA_LO   = 22,
   parameter int unsigned TT_CTX_POS = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] dptr_ps0,
   input logic [DATA_W-1:0] dptr_ps1,
   input logic [DATA_W-1:0] iptr_ps0,
   input logic [DATA_W-1:0] iptr_ps1
);
   localparam int unsigned VA_TOP = DATA_W - TT_VA_LO - 1;
   localparam int unsigned CTX_TOP = TT_CTX_POS + CTX_W - 1;
   localparam logic [ADDR_W-2:0] RO_SEL = '1;

   assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dptr_ps0 == '0 && dptr_ps1 == '0 && iptr_ps0 == '0 && iptr_ps1 == '0));

   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[ADDR_W-2:0] != RO_SEL)
      |=> (rd_addr != $past(wr_addr) || rd_data == $past(wr_data)));

   assert_tgt_gaps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[ADDR_W-2:0] == RO_SEL)
      |-> (rd_data[TT_CTX_POS-1:VA_TOP+1] == '0 && rd_data[DATA_W-1:CTX_TOP+1] == '0));

   assert_ro_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[ADDR_W-2:0] == RO_SEL)
      |=> ($stable(dptr_ps0) && $stable(dptr_ps1) && $stable(iptr_ps0) && $stable(iptr_ps1)));

   assert_ptr_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dptr_ps0[3:0] == '0 && dptr_ps1[3:0] == '0 && iptr_ps0[3:0] == '0 && iptr_ps1[3:0] == '0));
endmodule

bind tsbp_regbank tsbp_regbank_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .CTX_W      (CTX_W),
   .TT_VA_LO   (TT_VA_LO),
   .TT_CTX_POS (TT_CTX_POS)
) chk_i (.*);

// File: tb/tsbp_regbank_tb_top.sv
module tsbp_regbank_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic [63:0] dptr_ps0, dptr_ps1, iptr_ps0, iptr_ps1;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [63:0] shadow [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   tsbp_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .dptr_ps0(dptr_ps0), .dptr_ps1(dptr_ps1), .iptr_ps0(iptr_ps0), .iptr_ps1(iptr_ps1)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] tt_model(input logic [63:0] ta);
      return (ta >> 22) | ({51'd0, ta[12:0]} << 48);
   endfunction

   function automatic logic [63:0] ptr_model(input int side, input bit ps1);
      logic [63:0] ta, b, c, res, mask;
      int off, sz, code;
      off = side * 8;
      ta = shadow[off+6];
      if (ta[12:0] == 13'd0) begin
         b = ps1 ? shadow[off+1] : shadow[off+0];
         c = shadow[off+2];
      end else begin
         b = ps1 ? shadow[off+4] : shadow[off+3];
         c = shadow[off+5];
      end
      sz = int'(b[3:0]);
      code = ps1 ? int'(c[10:8]) : int'(c[2:0]);
      res = b & ~64'h1FFF;
      if (ps1 && b[12]) res[13+sz] = 1'b1;
      mask = '0;
      for (int k = 4; k <= 12 + sz; k++) mask[k] = 1'b1;
      res = res | ((ta >> (9 + 3*code)) & mask);
      return res;
   endfunction

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a[2:0] != 3'd7) shadow[a] = d;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [63:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic ptr_chk(input string req);
      #1;
      chk(req, dptr_ps0, ptr_model(0, 1'b0));
      chk(req, dptr_ps1, ptr_model(0, 1'b1));
      chk(req, iptr_ps0, ptr_model(1, 1'b0));
      chk(req, iptr_ps1, ptr_model(1, 1'b1));
   endtask

   task automatic t_reset;
      for (int a = 0; a < 16; a++) rd_chk("R1 reset read", 4'(a), 64'd0);
      chk("R1 reset dptr0", dptr_ps0, 0); chk("R1 reset dptr1", dptr_ps1, 0);
      chk("R1 reset iptr0", iptr_ps0, 0); chk("R1 reset iptr1", iptr_ps1, 0);
   endtask

   task automatic t_readback;
      for (int a = 0; a < 16; a++) begin
         if (a % 8 != 7) wr(4'(a), {32'hA5C3_0000 | 32'(a), 32'h1357_9BDF ^ 32'(a * 32'h0101_0101)});
      end
      for (int a = 0; a < 16; a++) begin
         if (a % 8 != 7) rd_chk("R2 readback", 4'(a), shadow[a]);
      end
   endtask

   task automatic t_tagtgt;
      wr(4'd6, 64'hFEDC_BA98_7654_3210);
      wr(4'd14, 64'h0123_4567_89AB_DEF1);
      rd_chk("R3 data tag target", 4'd7, tt_model(64'hFEDC_BA98_7654_3210));
      rd_chk("R3 inst tag target", 4'd15, tt_model(64'h0123_4567_89AB_DEF1));
   endtask

   task automatic t_ro_write;
      logic [63:0] d0, d1, i0, i1;
      #1; d0 = dptr_ps0; d1 = dptr_ps1; i0 = iptr_ps0; i1 = iptr_ps1;
      wr(4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(4'd15, 64'h0);
      rd_chk("R4 data tgt unchanged", 4'd7, tt_model(shadow[6]));
      rd_chk("R4 inst tgt unchanged", 4'd15, tt_model(shadow[14]));
      rd_chk("R4 tag access unchanged", 4'd6, shadow[6]);
      for (int a = 0; a < 6; a++) rd_chk("R4 regs unchanged", 4'(a), shadow[a]);
      #1;
      chk("R4 dptr0", dptr_ps0, d0); chk("R4 dptr1", dptr_ps1, d1);
      chk("R4 iptr0", iptr_ps0, i0); chk("R4 iptr1", iptr_ps1, i1);
   endtask

   task automatic t_ctx_sel;
      wr(4'd0, 64'h0000_0011_1110_0000);
      wr(4'd3, 64'h0000_0022_2220_0000);
      wr(4'd2, 64'h0);
      wr(4'd5, 64'h0);
      wr(4'd6, 64'h0000_0000_0004_0000);
      #1; chk("R5 kernel base", dptr_ps0 & ~64'h1FFF, 64'h0000_0011_1110_0000);
      ptr_chk("R5 kernel");
      wr(4'd6, 64'h0000_0000_0004_0001);
      #1; chk("R5 user base", dptr_ps0 & ~64'h1FFF, 64'h0000_0022_2220_0000);
      ptr_chk("R5 user");
   endtask

   task automatic t_index;
      for (int code = 0; code < 8; code++) begin
         for (int sz = 0; sz < 16; sz += 5) begin
            wr(4'd3, 64'h0000_4321_8765_E000 | 64'(sz));
            wr(4'd4, 64'h0000_1111_2222_C000 | 64'(sz));
            wr(4'd5, {53'd0, 3'(7 - code), 5'd0, 3'(code)});
            wr(4'd6, 64'h9E37_79B9_7F4A_7C15);
            ptr_chk("R6 R7 index and code");
         end
      end
      wr(4'd3, 64'h0);
      wr(4'd5, 64'h0000_0000_0000_0700);
      wr(4'd6, 64'h0000_0000_0000_1E01);
      #1; chk("R6 empty base low bits", dptr_ps0, 64'h0000_0000_0000_0000 | ((64'h1E01 >> 9) & 64'h1FF0));
      chk("R7 ps1 uses code 7", dptr_ps1, ptr_model(0, 1'b1));
   endtask

   task automatic t_split;
      wr(4'd3, 64'h0000_0000_0010_1006);
      wr(4'd4, 64'h0000_0000_0020_1006);
      wr(4'd5, 64'h0);
      wr(4'd6, 64'h0);
      wr(4'd6, 64'h0000_0000_0000_0005);
      #1;
      chk("R8 ps1 split bit 19", dptr_ps1, 64'h0000_0000_0020_0000 | 64'h0000_0000_0008_0000);
      chk("R8 ps0 ignores split", dptr_ps0, 64'h0000_0000_0010_0000);
      ptr_chk("R8 split model");
   endtask

   task automatic t_sides;
      logic [63:0] i0, i1;
      #1; i0 = iptr_ps0; i1 = iptr_ps1;
      wr(4'd6, 64'hDEAD_BEEF_CAFE_0123);
      wr(4'd3, 64'h0000_7777_0000_2003);
      #1;
      chk("R9 inst ptr0 untouched", iptr_ps0, i0);
      chk("R9 inst ptr1 untouched", iptr_ps1, i1);
      wr(4'd14, 64'h0000_0000_0123_4001);
      wr(4'd11, 64'h0000_3333_0000_0002);
      ptr_chk("R9 sides");
   endtask

   task automatic t_same_cycle;
      logic [63:0] old_ta, old_p;
      old_ta = shadow[6];
      #1; old_p = dptr_ps0;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd6; wr_data = old_ta ^ 64'h0000_00F0_F0F0_0000;
      rd_addr = 4'd6;
      #1;
      chk("R10 read before edge", rd_data, old_ta);
      chk("R10 ptr before edge", dptr_ps0, old_p);
      @(posedge clk); #1;
      wr_en = 1'b0;
      shadow[6] = old_ta ^ 64'h0000_00F0_F0F0_0000;
      chk("R10 read after edge", rd_data, shadow[6]);
      ptr_chk("R10 ptr after edge");
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd7; wr_data = '1; rd_addr = 4'd7;
      #1; chk("R4 tgt during ro write", rd_data, tt_model(shadow[6]));
      @(posedge clk); #1;
      wr_en = 1'b0;
      chk("R4 tgt after ro write", rd_data, tt_model(shadow[6]));
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      for (int a = 0; a < 16; a++) shadow[a] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_tagtgt();
      t_ro_write();
      t_ctx_sel();
      t_index();
      t_split();
      t_sides();
      t_same_cycle();
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule